// File: doc/BRIEF.md
# Repeated-Subtraction Signed Divider

This block divides one 8-bit two's-complement integer by another and returns an 8-bit quotient rounded toward zero. It turns both operands into unsigned magnitudes and notes whether exactly one of them was negative. It then takes the divisor magnitude away from the running dividend magnitude once per clock. It counts each subtraction that does not go below zero. When a difference goes below zero, the count is the magnitude of the quotient. The count is negated if the operand signs differed.

A caller raises `go` for one cycle with both operands while `busy` is low. The result arrives with a one-cycle `done` pulse. The run time grows with the size of the quotient, and no shifting is used. A zero divisor is not divided. It finishes at once with a zero quotient and the `div_zero` flag set.

Top module: `srdiv_top`

## Requirements
- R1: After reset, `quotient` is 0 and `done`, `busy` and `div_zero` are all 0.
- R2: A `go` seen while `busy` is low, with a nonzero divisor, is accepted on that clock edge, and `busy` is 1 after that edge.
- R3: When both operands have the same sign, `quotient` equals floor(|dividend| / |divisor|).
- R4: When exactly one operand is negative, `quotient` is the two's-complement negation of floor(|dividend| / |divisor|), which is truncation toward zero.
- R5: For a nonzero divisor, `done` rises on the (|q|+1)-th rising edge after the edge that accepts `go`, where |q| is the quotient magnitude.
- R6: `done` is high for exactly one cycle, and `busy` is 0 whenever `done` is 1.
- R7: A `go` that arrives while `busy` is 1 has no effect. The running division keeps its operands, its result and its timing.
- R8: A zero divisor seen with an accepted `go` gives `done` = 1, `div_zero` = 1 and `quotient` = 0 on the next edge, and `busy` never rises.
- R9: A completed division by a nonzero divisor clears `div_zero`.
- R10: Magnitudes up to 128 are compared correctly: -128 / -128 = 1, 127 / -128 = 0, and -128 / -1 and -128 / 1 both give 8'h80 (the true +128 wraps to 8 bits).
- R11: `quotient` and `div_zero` change only on the edge that raises `done`, and otherwise hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Start request, sampled when idle |
| dividend | input | 8 | Two's-complement dividend |
| divisor | input | 8 | Two's-complement divisor |
| quotient | output | 8 | Two's-complement quotient, held between results |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | High while subtractions are running |
| div_zero | output | 1 | Last completed request had a zero divisor |

## Verification
The operand pairs are chosen to exercise different paths:
- All four sign combinations. Only these show whether the final negation is applied exactly when one operand is negative.
- A dividend smaller than the divisor. This gives a zero quotient after a single pass.
- Exact multiples against near-multiples. These catch an off-by-one in the stop test.
- The value -128 used as dividend and as divisor. This exposes a subtractor too narrow to see the borrow.

Each run also measures latency in cycles against |q|+1. A second request is sent mid-run, and a zero divisor is placed between normal divisions so that the setting and clearing of the flag can be seen.

// File: rtl/srdiv_pkg.sv
package srdiv_pkg;

  typedef enum logic [0:0] {
    PH_IDLE = 1'b0,
    PH_LOOP = 1'b1
  } srdiv_phase_t;

endpackage

// File: rtl/srdiv_sign.sv
// Operand conditioning: magnitudes, result sign and zero-divisor detect.
module srdiv_sign #(
  parameter int W = 8
) (
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] num_mag_o,
  output logic [W-1:0] den_mag_o,
  output logic         neg_o,
  output logic         den_zero_o
);

  localparam int MSB = W - 1;

  logic sgn_acc;

  always_comb begin
    sgn_acc = 1'b0;
    den_mag_o = den_i;
    if (den_i[MSB]) begin
      den_mag_o = ~den_i + 1'b1;
      sgn_acc   = ~sgn_acc;
    end
    num_mag_o = num_i;
    if (num_i[MSB]) begin
      num_mag_o = ~num_i + 1'b1;
      sgn_acc   = ~sgn_acc;
    end
    neg_o      = sgn_acc;
    den_zero_o = (den_i == '0);
  end

endmodule

// File: rtl/srdiv_iter.sv
// Datapath: running remainder, divisor magnitude, count and sign.
module srdiv_iter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] num_mag_i,
  input  logic [W-1:0] den_mag_i,
  input  logic         neg_i,
  output logic         under_o,
  output logic [W-1:0] count_o,
  output logic         neg_o
);

  localparam int DW = W + 1;

  logic [W-1:0]  run_q;
  logic [W-1:0]  dvs_q;
  logic [W-1:0]  cnt_q;
  logic          neg_q;
  logic [DW-1:0] diff;

  // Extra top bit keeps the borrow visible for magnitudes up to 2^(W-1).
  assign diff    = {1'b0, run_q} - {1'b0, dvs_q};
  assign under_o = diff[DW-1];
  assign count_o = cnt_q;
  assign neg_o   = neg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      neg_q <= 1'b0;
    end else if (load_i) begin
      run_q <= num_mag_i;
      dvs_q <= den_mag_i;
      cnt_q <= '0;
      neg_q <= neg_i;
    end else if (step_i) begin
      run_q <= diff[W-1:0];
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/srdiv_ctrl.sv
// Sequencer: accept, iterate, finish.
module srdiv_ctrl
  import srdiv_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic go_i,
  input  logic den_zero_i,
  input  logic under_i,
  output logic load_o,
  output logic step_o,
  output logic fin_o,
  output logic fin_zero_o,
  output logic busy_o
);

  srdiv_phase_t ph_q, ph_d;
  logic busy_q;

  always_comb begin
    ph_d       = ph_q;
    load_o     = 1'b0;
    step_o     = 1'b0;
    fin_o      = 1'b0;
    fin_zero_o = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (go_i) begin
          if (den_zero_i) begin
            fin_zero_o = 1'b1;
          end else begin
            load_o = 1'b1;
            ph_d   = PH_LOOP;
          end
        end
      end
      PH_LOOP: begin
        if (under_i) begin
          fin_o = 1'b1;
          ph_d  = PH_IDLE;
        end else begin
          step_o = 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      busy_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      busy_q <= (ph_d == PH_LOOP);
    end
  end

  assign busy_o = busy_q;

endmodule

// File: rtl/srdiv_top.sv
module srdiv_top #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic         done,
  output logic         busy,
  output logic         div_zero
);

  logic [W-1:0] num_mag, den_mag, count;
  logic neg_in, den_zero, under, neg_run;
  logic load, step, fin, fin_zero;
  logic [W-1:0] quot_q;
  logic done_q, dz_q;

  srdiv_sign #(.W(W)) u_sign (
    .num_i(dividend), .den_i(divisor),
    .num_mag_o(num_mag), .den_mag_o(den_mag),
    .neg_o(neg_in), .den_zero_o(den_zero)
  );

  srdiv_iter #(.W(W)) u_iter (
    .clk(clk), .rst(rst), .load_i(load), .step_i(step),
    .num_mag_i(num_mag), .den_mag_i(den_mag), .neg_i(neg_in),
    .under_o(under), .count_o(count), .neg_o(neg_run)
  );

  srdiv_ctrl u_ctrl (
    .clk(clk), .rst(rst), .go_i(go), .den_zero_i(den_zero),
    .under_i(under), .load_o(load), .step_o(step),
    .fin_o(fin), .fin_zero_o(fin_zero), .busy_o(busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      quot_q <= '0;
      done_q <= 1'b0;
      dz_q   <= 1'b0;
    end else begin
      done_q <= fin | fin_zero;
      if (fin) begin
        quot_q <= neg_run ? (~count + 1'b1) : count;
        dz_q   <= 1'b0;
      end else if (fin_zero) begin
        quot_q <= '0;
        dz_q   <= 1'b1;
      end
    end
  end

  assign quotient = quot_q;
  assign done     = done_q;
  assign div_zero = dz_q;

endmodule

// File: rtl/srdiv_chk.sv
module srdiv_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         go,
  input logic [W-1:0] divisor,
  input logic [W-1:0] quotient,
  input logic         done,
  input logic         busy,
  input logic         div_zero
);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);  // R6
  AST_GO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (go && !busy && divisor != '0) |=> busy);  // R2
  AST_ZERO_FAST: assert property (@(posedge clk) disable iff (rst)
    (go && !busy && divisor == '0) |=> (done && div_zero && !busy));  // R8
  AST_ZERO_QUOT: assert property (@(posedge clk) disable iff (rst)
    div_zero |-> (quotient == '0));  // R8
  AST_HOLD_QUOT: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(quotient) && $stable(div_zero)));  // R11

endmodule

bind srdiv_top srdiv_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .go(go), .divisor(divisor),
  .quotient(quotient), .done(done), .busy(busy), .div_zero(div_zero)
);

// File: tb/tb_srdiv_top.sv
`timescale 1ns/1ps
module tb_srdiv_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       go = 1'b0;
  logic [7:0] dividend = '0;
  logic [7:0] divisor = '0;
  logic [7:0] quotient;
  logic       done, busy, div_zero;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  srdiv_top #(.W(8)) dut (
    .clk(clk), .rst(rst), .go(go), .dividend(dividend), .divisor(divisor),
    .quotient(quotient), .done(done), .busy(busy), .div_zero(div_zero)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_q(input int a, input int b);
    int q;
    if (b == 0) return 8'h00;
    q = a / b;
    return q[7:0];
  endfunction

  function automatic int mag_q(input int a, input int b);
    int q;
    q = a / b;
    return (q < 0) ? -q : q;
  endfunction

  // Launch one request and wait for done; returns cycles from the accept edge.
  task automatic run_div(input int a, input int b, input string req);
    int cyc;
    @(negedge clk);
    go = 1'b1; dividend = a[7:0]; divisor = b[7:0];
    @(negedge clk);
    go = 1'b0;
    cyc = 0;
    if (b != 0) check("R2 busy after accept", int'(busy), 1);
    while (!done && cyc < 400) begin
      @(negedge clk);
      cyc++;
      if (b == 0) check("R8 busy stays low", int'(busy), 0);
    end
    check({req, " quotient"}, int'(quotient), int'(ref_q(a, b)));
    check("R6 busy low with done", int'(busy), 0);
    if (b != 0) begin
      check("R5 latency", cyc, mag_q(a, b) + 1);
      check("R9 flag cleared", int'(div_zero), 0);
    end else begin
      check("R8 latency", cyc, 0);
      check("R8 flag set", int'(div_zero), 1);
    end
    @(negedge clk);
    check("R6 done one cycle", int'(done), 0);
    check("R11 quotient held", int'(quotient), int'(ref_q(a, b)));
  endtask

  task automatic t_reset();
    check("R1 quotient", int'(quotient), 0);
    check("R1 done", int'(done), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 div_zero", int'(div_zero), 0);
  endtask

  task automatic t_same_sign();
    run_div(100, 7, "R3");
    run_div(21, 7, "R3");
    run_div(20, 7, "R3");
    run_div(5, 9, "R3");
    run_div(-90, -9, "R3");
    run_div(-89, -9, "R3");
    run_div(0, 5, "R3");
  endtask

  task automatic t_mixed_sign();
    run_div(-100, 7, "R4");
    run_div(100, -7, "R4");
    run_div(-7, 3, "R4");
    run_div(3, -4, "R4");
  endtask

  task automatic t_zero();
    run_div(55, 0, "R8");
    run_div(55, 5, "R9");
    run_div(-3, 0, "R8");
  endtask

  task automatic t_extremes();
    run_div(-128, -128, "R10");
    run_div(127, -128, "R10");
    run_div(-128, -1, "R10");
    run_div(-128, 1, "R10");
    run_div(127, 1, "R10");
  endtask

  task automatic t_ignore_go();
    int cyc;
    @(negedge clk);
    go = 1'b1; dividend = 8'd100; divisor = 8'd3;
    @(negedge clk);
    go = 1'b0;
    cyc = 0;
    repeat (3) begin @(negedge clk); cyc++; end
    go = 1'b1; dividend = 8'd10; divisor = 8'd0;
    @(negedge clk);
    cyc++;
    go = 1'b0; dividend = 8'd10; divisor = 8'd2;
    check("R7 still busy", int'(busy), 1);
    while (!done && cyc < 400) begin @(negedge clk); cyc++; end
    check("R7 quotient", int'(quotient), 33);
    check("R7 latency", cyc, 34);
    check("R7 no zero flag", int'(div_zero), 0);
    @(negedge clk);
    check("R7 no second done", int'(done), 0);
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_same_sign();
    t_mixed_sign();
    t_zero();
    t_extremes();
    t_ignore_go();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule